// File: doc/BRIEF.md
# Teletext Service Packet Acquisition Unit

This block sits behind a line-framing front end. The front end delivers teletext row bytes that are already sliced and byte-aligned. Each byte carries tags for its row kind, its packet format and its index within the row. The block picks out the bytes that the selected acquisition mode asks for and assembles them in a 16-byte shadow buffer. When the row ends, it copies the whole buffer into a transfer register in a single cycle, and a host serial interface reads that register.

Four acquisition modes are available:
- **Format-1 service rows:** bytes are copied through raw.
- **Format-2 service rows:** every byte is protected by an extended Hamming 8/4 code. A byte with a single-bit error is repaired, and a byte with a double-bit error spoils the whole row.
- **Header rows, ordering A and ordering B:** two half-windows of the header are gathered in a fixed order.

A copy is dropped when the host is accessing the block at that moment. An active-low data-available output reports each fresh format-2 capture and clears when the host starts a read.

The byte input is a valid/ready stream. `in_ready` goes high on the first clock after reset is released and then stays high. A byte is taken on every clock edge where `in_valid` and `in_ready` are both high. The block never applies back-pressure, so the front end need not buffer.

Top module: `ttx_svc_acq`

## Requirements
- R1: During reset and after it, `xfer_data` is all zeros and `dav_n` is high until the first commit.
- R2: `in_ready` is high in every cycle after the first clock edge with reset released, so every valid byte is accepted.
- R3: With `acq_sel`=0, a service row (`in_kind`=1) with `in_fmt2`=0 copies its bytes at indices 13..28 unchanged into slots 0..15. Slot k is `xfer_data[8k+7:8k]`.
- R4: With `acq_sel`=1, a service row with `in_fmt2`=1 fills slots 0..15 from indices 9..24, and each byte is stored as its corrected codeword. The code has data bits at byte bits 3, 5, 6 and 7, and parity bits 1, 2 and 4 cover the byte bits whose position number has that bit set. Bit 0 makes the parity of the whole byte even. An error-free byte is stored unchanged, and a byte with one flipped bit is stored with that bit restored.
- R5: If a format-2 row has a double-bit error in any byte inside its window, nothing from that row is committed and the transfer register keeps its previous contents.
- R6: With `acq_sel`=2, a header row (`in_kind`=2) fills slots 0..7 from indices 38..45 and slots 8..15 from indices 30..37.
- R7: With `acq_sel`=3, a header row fills slots 0..7 from indices 22..29 and slots 8..15 from indices 14..21.
- R8: A row whose kind or format does not match the selected mode changes neither the transfer register nor `dav_n`.
- R9: The commit takes effect on the second clock edge after the row's last byte is accepted. It is dropped if `host_busy` is high in the cycle before that edge.
- R10: A row that does not deliver every one of the 16 slots is not committed.
- R11: `dav_n` goes low only on the commit of a format-2 row. Format-1 and header commits leave it unchanged.
- R12: A pulse on `host_rd_start` returns `dav_n` high. If a format-2 commit happens in the same cycle, the commit wins and `dav_n` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_sel | input | 2 | Mode: 0 format-1, 1 format-2, 2 header order A, 3 header order B |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready |
| in_data | input | 8 | Row byte |
| in_idx | input | 6 | Byte index within the row |
| in_kind | input | 2 | Row kind: 0 other, 1 service packet, 2 header |
| in_fmt2 | input | 1 | Service packet format: 0 format-1, 1 format-2 |
| in_last | input | 1 | Marks the final byte of a row |
| host_busy | input | 1 | Host serial access in progress |
| host_rd_start | input | 1 | Pulse when a host read of the transfer register begins |
| xfer_data | output | 128 | Transfer register, slot k at bits 8k+7..8k |
| dav_n | output | 1 | Data available, active low |

## Verification
The Hamming path is swept over every codeword, both clean and with each single bit flipped in turn, so storing the raw byte and correcting the wrong bit are told apart from proper repair. Double-bit errors are placed in each of the 16 slots in turn, which shows that any one bad byte vetoes the whole row. Index-dependent patterns in the raw and header modes reveal a wrong base, a swapped half or an off-by-one window. Junk bytes that lie outside the window, or that belong to rows of the wrong kind, confirm that only qualifying bytes count.

// File: rtl/ttx_acq_pkg.sv
package ttx_acq_pkg;
  typedef enum logic [1:0] {
    ACQ_FMT1  = 2'd0,
    ACQ_FMT2  = 2'd1,
    ACQ_HDR_A = 2'd2,
    ACQ_HDR_B = 2'd3
  } acq_sel_e;

  typedef enum logic [1:0] {
    ROW_OTHER = 2'd0,
    ROW_SVC   = 2'd1,
    ROW_HDR   = 2'd2
  } row_kind_e;
endpackage

// File: rtl/ttx_ham84_fix.sv
module ttx_ham84_fix (
  input  logic [7:0] code_in,
  output logic [7:0] code_fix,
  output logic       code_bad
);
  logic [2:0] syn;
  logic       par;

  always_comb begin
    syn = 3'd0;
    for (int i = 1; i < 8; i++) begin
      if (code_in[i]) syn = syn ^ 3'(i);
    end
    par      = ^code_in;
    code_fix = code_in;
    code_bad = 1'b0;
    if (par) begin
      code_fix[syn] = ~code_in[syn];
    end else if (syn != 3'd0) begin
      code_bad = 1'b1;
    end
  end
endmodule

// File: rtl/ttx_slot_map.sv
module ttx_slot_map
  import ttx_acq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int IDX_W    = 6,
  parameter int F1_FIRST = 13,
  parameter int F2_FIRST = 9,
  parameter int A_HI     = 38,
  parameter int A_LO     = 30,
  parameter int B_HI     = 22,
  parameter int B_LO     = 14,
  localparam int SLOT_W  = $clog2(DEPTH)
) (
  input  logic [1:0]        sel,
  input  logic [1:0]        kind,
  input  logic              fmt2,
  input  logic [IDX_W-1:0]  idx,
  output logic              row_match,
  output logic              slot_hit,
  output logic [SLOT_W-1:0] slot
);
  localparam int HALF = DEPTH / 2;

  int iv;
  int sv;
  int hi_base;
  int lo_base;

  always_comb begin
    iv        = int'(idx);
    sv        = 0;
    slot_hit  = 1'b0;
    row_match = 1'b0;
    hi_base   = (sel == ACQ_HDR_A) ? A_HI : B_HI;
    lo_base   = (sel == ACQ_HDR_A) ? A_LO : B_LO;
    unique case (acq_sel_e'(sel))
      ACQ_FMT1: begin
        row_match = (kind == ROW_SVC) && !fmt2;
        if (iv >= F1_FIRST && iv < F1_FIRST + DEPTH) begin
          slot_hit = 1'b1;
          sv       = iv - F1_FIRST;
        end
      end
      ACQ_FMT2: begin
        row_match = (kind == ROW_SVC) && fmt2;
        if (iv >= F2_FIRST && iv < F2_FIRST + DEPTH) begin
          slot_hit = 1'b1;
          sv       = iv - F2_FIRST;
        end
      end
      default: begin
        row_match = (kind == ROW_HDR);
        if (iv >= hi_base && iv < hi_base + HALF) begin
          slot_hit = 1'b1;
          sv       = iv - hi_base;
        end else if (iv >= lo_base && iv < lo_base + HALF) begin
          slot_hit = 1'b1;
          sv       = iv - lo_base + HALF;
        end
      end
    endcase
    slot = sv[SLOT_W-1:0];
  end
endmodule

// File: rtl/ttx_shadow_buf.sv
module ttx_shadow_buf #(
  parameter int DEPTH   = 16,
  localparam int SLOT_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SLOT_W-1:0]    wr_slot,
  input  logic [7:0]           wr_data,
  input  logic                 wr_coded,
  input  logic                 wr_bad,
  input  logic                 row_end,
  input  logic                 row_end_match,
  output logic [DEPTH*8-1:0]   shadow_flat,
  output logic                 row_done,
  output logic                 row_ok
);
  logic [7:0]       buf_q [DEPTH];
  logic [DEPTH-1:0] mask_q;
  logic             err_q;
  logic [DEPTH-1:0] cur_bit;
  logic             cur_bad;

  assign cur_bit = wr_en ? (DEPTH'(1) << wr_slot) : '0;
  assign cur_bad = wr_en && wr_bad;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        buf_q[g] <= 8'h00;
      end else if (wr_en && !wr_bad && (wr_slot == SLOT_W'(g))) begin
        buf_q[g] <= wr_data;
      end
    end
    assign shadow_flat[8*g +: 8] = buf_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '0;
      err_q    <= 1'b0;
      row_done <= 1'b0;
      row_ok   <= 1'b0;
    end else if (row_end) begin
      mask_q   <= '0;
      err_q    <= 1'b0;
      row_done <= row_end_match;
      row_ok   <= (&(mask_q | cur_bit)) && !(err_q || cur_bad);
    end else begin
      row_done <= 1'b0;
      if (wr_en) begin
        mask_q <= mask_q | cur_bit;
        err_q  <= err_q | cur_bad;
      end
    end
  end

  // R4
  code_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_coded && !wr_bad) |-> (^wr_data == 1'b0));
endmodule

// File: rtl/ttx_svc_acq.sv
module ttx_svc_acq
  import ttx_acq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int IDX_W    = 6,
  parameter int F1_FIRST = 13,
  parameter int F2_FIRST = 9,
  parameter int A_HI     = 38,
  parameter int A_LO     = 30,
  parameter int B_HI     = 22,
  parameter int B_LO     = 14,
  localparam int SLOT_W  = $clog2(DEPTH),
  localparam int XW      = DEPTH * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       acq_sel,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic [IDX_W-1:0] in_idx,
  input  logic [1:0]       in_kind,
  input  logic             in_fmt2,
  input  logic             in_last,
  input  logic             host_busy,
  input  logic             host_rd_start,
  output logic [XW-1:0]    xfer_data,
  output logic             dav_n
);
  logic              ready_q;
  logic              accept;
  logic              row_match;
  logic              slot_hit;
  logic [SLOT_W-1:0] slot;
  logic [7:0]        fix_byte;
  logic              fix_bad;
  logic              coded;
  logic [XW-1:0]     shadow_flat;
  logic              row_done;
  logic              row_ok;
  logic              row_f2_q;
  logic              commit;
  logic [XW-1:0]     xfer_q;
  logic              dav_q;

  assign in_ready = ready_q;
  assign accept   = in_valid && ready_q;
  assign coded    = (acq_sel == ACQ_FMT2);

  ttx_slot_map #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .F1_FIRST(F1_FIRST), .F2_FIRST(F2_FIRST),
    .A_HI(A_HI), .A_LO(A_LO), .B_HI(B_HI), .B_LO(B_LO)
  ) u_map (
    .sel(acq_sel), .kind(in_kind), .fmt2(in_fmt2), .idx(in_idx),
    .row_match(row_match), .slot_hit(slot_hit), .slot(slot)
  );

  ttx_ham84_fix u_ham (
    .code_in(in_data), .code_fix(fix_byte), .code_bad(fix_bad)
  );

  ttx_shadow_buf #(.DEPTH(DEPTH)) u_shadow (
    .clk(clk), .rst_n(rst_n),
    .wr_en(accept && row_match && slot_hit),
    .wr_slot(slot),
    .wr_data(coded ? fix_byte : in_data),
    .wr_coded(coded),
    .wr_bad(coded && fix_bad),
    .row_end(accept && in_last),
    .row_end_match(row_match),
    .shadow_flat(shadow_flat),
    .row_done(row_done),
    .row_ok(row_ok)
  );

  assign commit = row_done && row_ok && !host_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q  <= 1'b0;
      row_f2_q <= 1'b0;
      xfer_q   <= '0;
      dav_q    <= 1'b1;
    end else begin
      ready_q <= 1'b1;
      if (accept && in_last) row_f2_q <= coded;
      if (commit) xfer_q <= shadow_flat;
      if (commit && row_f2_q) dav_q <= 1'b0;
      else if (host_rd_start) dav_q <= 1'b1;
    end
  end

  assign xfer_data = xfer_q;
  assign dav_n     = dav_q;

  // R2
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(xfer_q) |-> !$past(host_busy));

  // R11
  dav_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dav_q) |-> $past(row_done && row_ok));

  // R12
  dav_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dav_q) |-> $past(host_rd_start));
endmodule

// File: tb/tb_ttx_svc_acq.sv
module tb_ttx_svc_acq;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   acq_sel = 2'd0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [7:0]   in_data = 8'h00;
  logic [5:0]   in_idx = 6'd0;
  logic [1:0]   in_kind = 2'd0;
  logic         in_fmt2 = 1'b0;
  logic         in_last = 1'b0;
  logic         host_busy = 1'b0;
  logic         host_rd_start = 1'b0;
  logic [127:0] xfer_data;
  logic         dav_n;

  int checks = 0;
  int fails = 0;
  logic [7:0] rowbuf [0:63];
  logic [7:0] exp_b [0:15];
  logic       exp_dav = 1'b1;
  logic       rd_at_commit = 1'b0;

  always #5 clk = ~clk;

  ttx_svc_acq dut (
    .clk(clk), .rst_n(rst_n), .acq_sel(acq_sel), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_idx(in_idx), .in_kind(in_kind),
    .in_fmt2(in_fmt2), .in_last(in_last), .host_busy(host_busy),
    .host_rd_start(host_rd_start), .xfer_data(xfer_data), .dav_n(dav_n)
  );

  function automatic logic [7:0] enc(input logic [3:0] n);
    logic [7:0] b;
    b = 8'h00;
    b[3] = n[0]; b[5] = n[1]; b[6] = n[2]; b[7] = n[3];
    b[1] = b[3] ^ b[5] ^ b[7];
    b[2] = b[3] ^ b[6] ^ b[7];
    b[4] = b[5] ^ b[6] ^ b[7];
    b[0] = ^b[7:1];
    return b;
  endfunction

  // nearest codeword within distance 1; returns 1 when none exists
  function automatic logic near_code(input logic [7:0] v, output logic [7:0] o);
    o = v;
    for (int n = 0; n < 16; n++) begin
      if ($countones(v ^ enc(4'(n))) <= 1) begin
        o = enc(4'(n));
        return 1'b0;
      end
    end
    return 1'b1;
  endfunction

  function automatic int src_idx(input logic [1:0] s, input int k);
    case (s)
      2'd0: return 13 + k;
      2'd1: return 9 + k;
      2'd2: return (k < 8) ? 38 + k : 30 + k - 8;
      default: return (k < 8) ? 22 + k : 14 + k - 8;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] expv);
    checks++;
    if (got !== expv) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, expv);
    end
  endtask

  task automatic model_row(input logic [1:0] kind, input logic f2, input int len);
    logic match;
    logic bad;
    logic [7:0] tmp [0:15];
    logic [7:0] o;
    int si;
    case (acq_sel)
      2'd0: match = (kind == 2'd1) && !f2;
      2'd1: match = (kind == 2'd1) && f2;
      default: match = (kind == 2'd2);
    endcase
    bad = 1'b0;
    for (int k = 0; k < 16; k++) begin
      si = src_idx(acq_sel, k);
      if (si >= len) bad = 1'b1;
      tmp[k] = rowbuf[si];
      if (acq_sel == 2'd1) begin
        if (near_code(rowbuf[si], o)) bad = 1'b1;
        tmp[k] = o;
      end
    end
    if (match && !bad && !host_busy) begin
      for (int k = 0; k < 16; k++) exp_b[k] = tmp[k];
      if (acq_sel == 2'd1) exp_dav = 1'b0;
    end
  endtask

  task automatic send_row(input logic [1:0] kind, input logic f2, input int len);
    model_row(kind, f2, len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_kind = kind; in_fmt2 = f2;
      in_idx = 6'(i); in_data = rowbuf[i]; in_last = (i == len - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    if (rd_at_commit) host_rd_start = 1'b1;
    @(negedge clk);
    host_rd_start = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_store(input string req);
    for (int k = 0; k < 16; k++) check(req, 32'(xfer_data[8*k +: 8]), 32'(exp_b[k]));
    check({req, " dav_n"}, 32'(dav_n), 32'(exp_dav));
  endtask

  task automatic fill_junk(input int seed);
    for (int i = 0; i < 64; i++) rowbuf[i] = 8'((i * 37 + seed * 11) ^ 8'hA5);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) exp_b[k] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state while held in reset
    check("R1 reset xfer", 32'(xfer_data != 128'd0), 32'd0);
    check("R1 reset dav_n", 32'(dav_n), 32'd1);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R2 ready", 32'(in_ready), 32'd1);
    check_store("R1 after reset");

    // R3 raw format-1 copy
    acq_sel = 2'd0;
    for (int s = 0; s < 3; s++) begin
      fill_junk(s);
      send_row(2'd1, 1'b0, 40);
      check_store("R3 fmt1 copy");
      check("R2 ready held", 32'(in_ready), 32'd1);
    end

    // R8 non-matching rows ignored
    fill_junk(7);
    send_row(2'd1, 1'b1, 40);
    check_store("R8 fmt2 row in fmt1 mode");
    send_row(2'd2, 1'b0, 46);
    check_store("R8 header row in fmt1 mode");
    send_row(2'd0, 1'b0, 40);
    check_store("R8 other row");

    // R4 Hamming sweep: clean and every single-bit flip
    acq_sel = 2'd1;
    for (int j = 0; j < 9; j++) begin
      fill_junk(j + 20);
      for (int k = 0; k < 16; k++)
        rowbuf[9 + k] = enc(4'((k + j) % 16)) ^ ((j == 0) ? 8'h00 : 8'(1 << (j - 1)));
      send_row(2'd1, 1'b1, 40);
      check_store("R4 fmt2 correct");
    end
    // R11 dav low after fmt2 commit
    check("R11 dav low", 32'(dav_n), 32'd0);

    // R12 host read start clears dav
    @(negedge clk); host_rd_start = 1'b1;
    @(negedge clk); host_rd_start = 1'b0;
    exp_dav = 1'b1;
    check("R12 dav cleared", 32'(dav_n), 32'd1);

    // R5 double-bit error in each slot vetoes the row
    for (int p = 0; p < 16; p++) begin
      for (int k = 0; k < 16; k++) rowbuf[9 + k] = enc(4'(15 - k));
      rowbuf[9 + p] = rowbuf[9 + p] ^ 8'(1 << (p % 8)) ^ 8'(1 << ((p + 3) % 8));
      send_row(2'd1, 1'b1, 40);
      check_store("R5 double error");
    end

    // R10 incomplete row
    for (int k = 0; k < 16; k++) rowbuf[9 + k] = enc(4'(k ^ 5));
    send_row(2'd1, 1'b1, 24);
    check_store("R10 short row");

    // R9 busy host blocks commit
    host_busy = 1'b1;
    send_row(2'd1, 1'b1, 40);
    host_busy = 1'b0;
    check_store("R9 busy drop");

    // R6 header order A
    acq_sel = 2'd2;
    fill_junk(40);
    send_row(2'd2, 1'b0, 46);
    check_store("R6 header A");
    // R11 header commit leaves dav high
    check("R11 header no dav", 32'(dav_n), 32'd1);

    // R7 header order B
    acq_sel = 2'd3;
    fill_junk(41);
    send_row(2'd2, 1'b0, 46);
    check_store("R7 header B");
    fill_junk(42);
    send_row(2'd1, 1'b0, 40);
    check_store("R8 service row in header mode");

    // R11 format-1 commit leaves dav high
    acq_sel = 2'd0;
    fill_junk(43);
    send_row(2'd1, 1'b0, 40);
    check_store("R11 fmt1 no dav");

    // R12 commit wins over simultaneous read start
    acq_sel = 2'd1;
    for (int k = 0; k < 16; k++) rowbuf[9 + k] = enc(4'(k * 3));
    rd_at_commit = 1'b1;
    send_row(2'd1, 1'b1, 40);
    rd_at_commit = 1'b0;
    check_store("R12 commit wins");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule